// File: doc/BRIEF.md
# Per-Plane Link Reset Propagator

This block carries reset across one multi-root link separately for every virtual plane. The local side presents a reset level for each plane. The block remembers which level the link partner has confirmed for each group of sixteen planes. When the two differ, it sends a reset DLLP carrying the full sixteen-plane state of that group and waits for the partner's acknowledge. If no matching acknowledge arrives within a programmable number of cycles, it sends the same group state again.

In the other direction, the block decodes reset DLLPs from the partner and keeps a mirror of the partner's reset level for every plane. It acknowledges each one by echoing the group and the state. It raises a one-cycle flush request for every plane that newly enters reset, so that the buffers holding that plane's traffic can be emptied. Reset DLLPs use a type code that is reserved in the base protocol. They never wait on TLP flow control, so reset on a stalled plane still makes progress. CRC generation and slot scheduling belong to the neighbouring link layer.

Top module: `rpl_link_reset`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `tx_valid`, `partner_reset` and `flush_req` are all zero.
- R2: Every DLLP word carries type 8'h70 in bits [31:24], the acknowledge flag in bit 23 (1 = acknowledge, 0 = state), zeros in bits [22:20], the group index in bits [19:16] and a 16-bit state bitmap in bits [15:0]. Bitmap bit i stands for plane group*16+i, and a 1 means the plane is in reset.
- R3: When the local level of some group differs from the level the partner has confirmed, and no state DLLP is outstanding, a state DLLP for the lowest such group is loaded at the next clock edge. It carries that group's current local levels.
- R4: Only one state DLLP is outstanding at a time. It is confirmed only by an acknowledge with the same group and the same bitmap. An acknowledge that does not match is ignored.
- R5: If no matching acknowledge arrives, the same DLLP word is loaded again exactly `timeout_cycles`+1 cycles after the previous load.
- R6: A received state DLLP for an existing group replaces that group's 16 bits of `partner_reset` at the clock edge that samples it. Apart from such a DLLP, `partner_reset` does not change.
- R7: `flush_req` pulses for one cycle, in the same cycle the mirror updates, for exactly the planes whose partner bit goes from 0 to 1.
- R8: Every received state DLLP is answered with an acknowledge DLLP that echoes its group and bitmap. A state that repeats the stored mirror is still acknowledged but raises no flush.
- R9: When an acknowledge and a state DLLP both wait for the transmit slot, the acknowledge goes first and the state DLLP goes in the next slot.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_dllp` holds its value. Reception, the mirror and flushes continue during such a stall.
- R11: A received word whose type field is not 8'h70 changes no state and is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_reset | input | NUM_GROUPS*16 | Local reset level per plane |
| timeout_cycles | input | TIMER_W | Cycles to wait for an acknowledge before resending |
| rx_valid | input | 1 | Received DLLP word valid this cycle |
| rx_dllp | input | 32 | Received DLLP word |
| tx_ready | input | 1 | Link layer accepts the offered DLLP |
| tx_valid | output | 1 | DLLP offered for transmission |
| tx_dllp | output | 32 | Offered DLLP word |
| partner_reset | output | NUM_GROUPS*16 | Mirror of the partner's reset level per plane |
| flush_req | output | NUM_GROUPS*16 | One-cycle flush request per plane entering reset |

## Verification
Two functions compete for the single transmit slot: echoing a partner's state with an acknowledge, and announcing a local level change. The bench creates the clash by delivering a partner state DLLP at one edge and changing a local plane level just after it. Both requests then meet at the next edge. The bench expects the acknowledge word first and the state word one cycle later. A second race sets the resend timer against a non-matching acknowledge. The bench expects the retransmission at exactly the timed cycle. A third race sets reception against a stalled transmitter. The bench checks that the mirror and the flushes advance while the offered word stays frozen.

// File: rtl/rpl_pkg.sv
package rpl_pkg;
  localparam int unsigned GRP_PLANES = 16;
  localparam int unsigned GIDX_W     = 4;
  localparam logic [7:0]  RST_KIND   = 8'h70;

  typedef struct packed {
    logic [7:0]            kind;
    logic                  ack;
    logic [2:0]            rsvd;
    logic [GIDX_W-1:0]     grp;
    logic [GRP_PLANES-1:0] map;
  } rst_dllp_t;

  function automatic rst_dllp_t make_dllp(input logic is_ack,
                                          input logic [GIDX_W-1:0] g,
                                          input logic [GRP_PLANES-1:0] m);
    rst_dllp_t d;
    d.kind = RST_KIND;
    d.ack  = is_ack;
    d.rsvd = 3'b000;
    d.grp  = g;
    d.map  = m;
    return d;
  endfunction
endpackage

// File: rtl/rpl_first_diff.sv
module rpl_first_diff
  import rpl_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16,
  localparam int unsigned NP = NUM_GROUPS * GRP_PLANES
) (
  input  logic [NP-1:0]     want,
  input  logic [NP-1:0]     have,
  output logic              any,
  output logic [GIDX_W-1:0] idx
);
  logic [NUM_GROUPS-1:0] differs;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cmp
    assign differs[g] = want[g*GRP_PLANES +: GRP_PLANES] != have[g*GRP_PLANES +: GRP_PLANES];
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (differs[g]) begin
        any = 1'b1;
        idx = g[GIDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rpl_rx.sv
module rpl_rx
  import rpl_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16,
  localparam int unsigned NP = NUM_GROUPS * GRP_PLANES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_valid,
  input  logic [31:0]           rx_dllp,
  output logic                  st_seen,
  output logic                  ack_seen,
  output logic [GIDX_W-1:0]     rx_grp,
  output logic [GRP_PLANES-1:0] rx_map,
  output logic [NP-1:0]         partner_q,
  output logic [NP-1:0]         flush_q
);
  rst_dllp_t d;
  logic      ok;

  assign d        = rst_dllp_t'(rx_dllp);
  assign ok       = rx_valid && (d.kind == RST_KIND) && (32'(d.grp) < NUM_GROUPS);
  assign st_seen  = ok && !d.ack;
  assign ack_seen = ok && d.ack;
  assign rx_grp   = d.grp;
  assign rx_map   = d.map;

  always_ff @(posedge clk) begin
    if (rst) begin
      partner_q <= '0;
      flush_q   <= '0;
    end else begin
      flush_q <= '0;
      if (st_seen) begin
        partner_q[rx_grp*GRP_PLANES +: GRP_PLANES] <= rx_map;
        flush_q[rx_grp*GRP_PLANES +: GRP_PLANES]   <=
          rx_map & ~partner_q[rx_grp*GRP_PLANES +: GRP_PLANES];
      end
    end
  end
endmodule

// File: rtl/rpl_tx.sv
module rpl_tx
  import rpl_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16,
  parameter int unsigned TIMER_W    = 16,
  localparam int unsigned NP = NUM_GROUPS * GRP_PLANES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NP-1:0]         loc_reset,
  input  logic [TIMER_W-1:0]    timeout_cycles,
  input  logic                  st_seen,
  input  logic                  ack_seen,
  input  logic [GIDX_W-1:0]     rx_grp,
  input  logic [GRP_PLANES-1:0] rx_map,
  input  logic                  tx_ready,
  output logic                  tx_valid,
  output logic [31:0]           tx_dllp
);
  typedef enum logic {S_IDLE, S_WAIT} st_e;

  st_e                   st;
  logic [NP-1:0]         confirmed;
  logic [GIDX_W-1:0]     cur_grp, ackp_grp, pick_grp, send_grp;
  logic [GRP_PLANES-1:0] cur_map, ackp_map, send_map;
  logic [TIMER_W-1:0]    timer;
  logic                  ackp, pick_any, slot, resend, send_req;
  logic                  load_ack, load_st, ack_match;

  rpl_first_diff #(.NUM_GROUPS(NUM_GROUPS)) u_pick (
    .want(loc_reset), .have(confirmed), .any(pick_any), .idx(pick_grp)
  );

  assign slot      = !tx_valid || tx_ready;
  assign resend    = (st == S_WAIT) && (timer == timeout_cycles);
  assign send_req  = ((st == S_IDLE) && pick_any) || resend;
  assign load_ack  = slot && ackp;
  assign load_st   = slot && !ackp && send_req;
  assign send_grp  = (st == S_IDLE) ? pick_grp : cur_grp;
  assign send_map  = (st == S_IDLE) ? loc_reset[pick_grp*GRP_PLANES +: GRP_PLANES] : cur_map;
  assign ack_match = (st == S_WAIT) && ack_seen && (rx_grp == cur_grp) && (rx_map == cur_map);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      confirmed <= '0;
      cur_grp   <= '0;
      cur_map   <= '0;
      ackp      <= 1'b0;
      ackp_grp  <= '0;
      ackp_map  <= '0;
      timer     <= '0;
      tx_valid  <= 1'b0;
      tx_dllp   <= '0;
    end else begin
      if (st_seen) begin
        ackp     <= 1'b1;
        ackp_grp <= rx_grp;
        ackp_map <= rx_map;
      end else if (load_ack) begin
        ackp <= 1'b0;
      end

      if (load_ack) begin
        tx_valid <= 1'b1;
        tx_dllp  <= make_dllp(1'b1, ackp_grp, ackp_map);
      end else if (load_st) begin
        tx_valid <= 1'b1;
        tx_dllp  <= make_dllp(1'b0, send_grp, send_map);
      end else if (slot) begin
        tx_valid <= 1'b0;
      end

      if (load_st) begin
        timer   <= '0;
        st      <= S_WAIT;
        cur_grp <= send_grp;
        cur_map <= send_map;
      end else if (st == S_WAIT && timer != timeout_cycles) begin
        timer <= timer + 1'b1;
      end

      if (ack_match) begin
        st <= S_IDLE;
        confirmed[cur_grp*GRP_PLANES +: GRP_PLANES] <= cur_map;
      end
    end
  end
endmodule

// File: rtl/rpl_link_reset.sv
module rpl_link_reset
  import rpl_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16,
  parameter int unsigned TIMER_W    = 16,
  localparam int unsigned NP = NUM_GROUPS * GRP_PLANES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NP-1:0]      loc_reset,
  input  logic [TIMER_W-1:0] timeout_cycles,
  input  logic               rx_valid,
  input  logic [31:0]        rx_dllp,
  input  logic               tx_ready,
  output logic               tx_valid,
  output logic [31:0]        tx_dllp,
  output logic [NP-1:0]      partner_reset,
  output logic [NP-1:0]      flush_req
);
  logic                  st_seen, ack_seen;
  logic [GIDX_W-1:0]     rx_grp;
  logic [GRP_PLANES-1:0] rx_map;

  rpl_rx #(.NUM_GROUPS(NUM_GROUPS)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_dllp(rx_dllp),
    .st_seen(st_seen), .ack_seen(ack_seen), .rx_grp(rx_grp), .rx_map(rx_map),
    .partner_q(partner_reset), .flush_q(flush_req)
  );

  rpl_tx #(.NUM_GROUPS(NUM_GROUPS), .TIMER_W(TIMER_W)) u_tx (
    .clk(clk), .rst(rst), .loc_reset(loc_reset), .timeout_cycles(timeout_cycles),
    .st_seen(st_seen), .ack_seen(ack_seen), .rx_grp(rx_grp), .rx_map(rx_map),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_dllp(tx_dllp)
  );
endmodule

// File: rtl/rpl_link_reset_chk.sv
module rpl_link_reset_chk #(
  parameter int unsigned NUM_GROUPS = 16,
  localparam int unsigned NP = NUM_GROUPS * 16
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_valid,
  input logic [31:0]   rx_dllp,
  input logic          tx_ready,
  input logic          tx_valid,
  input logic [31:0]   tx_dllp,
  input logic [NP-1:0] partner_reset,
  input logic [NP-1:0] flush_req
);
  AST_TX_FORMAT: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_dllp[31:24] == 8'h70 && tx_dllp[22:20] == 3'b000)); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_dllp))); // R10
  AST_FLUSH_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    ((flush_req & ~partner_reset) == '0)); // R7
  AST_FLUSH_NEW_ONLY: assert property (@(posedge clk) disable iff (rst)
    ((flush_req & $past(partner_reset)) == '0)); // R7
  AST_MIRROR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> ($stable(partner_reset) && flush_req == '0)); // R6
  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_dllp[31:24] != 8'h70) |=> ($stable(partner_reset) && flush_req == '0)); // R11
endmodule

bind rpl_link_reset rpl_link_reset_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_dllp(rx_dllp),
  .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_dllp(tx_dllp),
  .partner_reset(partner_reset), .flush_req(flush_req)
);

// File: tb/rpl_link_reset_test.sv
module rpl_link_reset_test;
  localparam int NG = 16;
  localparam int NP = NG * 16;
  localparam int TMO = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] loc_reset = '0;
  logic [15:0]   timeout_cycles = 16'(TMO);
  logic          rx_valid = 1'b0;
  logic [31:0]   rx_dllp = '0;
  logic          tx_ready = 1'b1;
  logic          tx_valid;
  logic [31:0]   tx_dllp;
  logic [NP-1:0] partner_reset, flush_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rpl_link_reset #(.NUM_GROUPS(NG), .TIMER_W(16)) uut (
    .clk(clk), .rst(rst), .loc_reset(loc_reset), .timeout_cycles(timeout_cycles),
    .rx_valid(rx_valid), .rx_dllp(rx_dllp), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_dllp(tx_dllp),
    .partner_reset(partner_reset), .flush_req(flush_req)
  );

  function automatic logic [31:0] mk(input bit a, input int g, input logic [15:0] m);
    return {8'h70, a, 3'b000, 4'(g), m};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model of the partner mirror and flush pulses (R6, R7, R11)
  logic [NP-1:0] m_partner = '0;
  logic [NP-1:0] m_flush = '0;
  always @(posedge clk) begin
    if (rst) begin
      m_partner <= '0;
      m_flush   <= '0;
    end else begin
      logic [NP-1:0] nf;
      nf = '0;
      if (rx_valid && rx_dllp[31:24] == 8'h70 && !rx_dllp[23]) begin
        for (int i = 0; i < 16; i++) begin
          int p;
          p = int'(rx_dllp[19:16]) * 16 + i;
          if (rx_dllp[i] && !m_partner[p]) nf[p] = 1'b1;
          m_partner[p] <= rx_dllp[i];
        end
      end
      m_flush <= nf;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (partner_reset != m_partner || flush_req != m_flush) begin
        errors++;
        $display("FAIL R6/R7: mirror %h flush %h expected %h / %h",
                 partner_reset, flush_req, m_partner, m_flush);
      end
    end
  end

  task automatic rx_send(input logic [31:0] w);
    @(negedge clk); rx_valid = 1'b1; rx_dllp = w;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic wait_tx(input logic [31:0] exp, input string req);
    bit seen;
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      if (tx_valid) begin
        seen = 1;
        check(tx_dllp == exp, req, tx_dllp, exp);
      end
    end
    if (!seen) check(1'b0, req, 32'h0, exp);
  endtask

  task automatic next_tx(input logic [31:0] exp, input string req);
    @(negedge clk);
    check(tx_valid && tx_dllp == exp, req, tx_valid ? tx_dllp : 32'hxxxxxxxx, exp);
  endtask

  task automatic expect_quiet(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(!tx_valid, req, tx_dllp, 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    check(!tx_valid && partner_reset == '0 && flush_req == '0, "R1",
          {31'h0, tx_valid}, 32'h0);

    // R3/R2: planes 32 and 35 -> group 2 bitmap 0009
    loc_reset[32] = 1'b1; loc_reset[35] = 1'b1;
    next_tx(mk(0, 2, 16'h0009), "R3");
    rx_send(mk(1, 2, 16'h0009));
    expect_quiet(TMO + 5, "R4 confirmed no resend");

    // R5 with non-matching ack in between (R4)
    loc_reset[200] = 1'b1;
    next_tx(mk(0, 12, 16'h0100), "R3 group12");
    begin
      int gap;
      gap = -1;
      for (int k = 1; k <= 40 && gap < 0; k++) begin
        @(negedge clk);
        if (k == 3) begin rx_valid = 1'b1; rx_dllp = mk(1, 12, 16'h0101); end
        if (k == 4) rx_valid = 1'b0;
        if (tx_valid) begin
          gap = k;
          check(tx_dllp == mk(0, 12, 16'h0100), "R5 same word", tx_dllp, mk(0, 12, 16'h0100));
        end
      end
      check(gap == TMO + 1, "R5/R4 resend timing", 32'(gap), 32'(TMO + 1));
    end
    rx_send(mk(1, 12, 16'h0100));
    expect_quiet(3, "R4 ack accepted");

    // R3 lowest group first
    loc_reset[85] = 1'b1; loc_reset[17] = 1'b1;
    next_tx(mk(0, 1, 16'h0002), "R3 lowest group");
    rx_send(mk(1, 1, 16'h0002));
    wait_tx(mk(0, 5, 16'h0020), "R3 next group");
    rx_send(mk(1, 5, 16'h0020));
    expect_quiet(3, "R3 all confirmed");

    // R6/R7/R8 partner state
    rx_send(mk(0, 3, 16'h0011));
    check(flush_req[48] && flush_req[52], "R7 flush pulse", flush_req[63:32], 32'h00110000);
    next_tx(mk(1, 3, 16'h0011), "R8 echo");
    check(flush_req == '0, "R7 single cycle", flush_req[63:32], 32'h0);
    rx_send(mk(0, 3, 16'h0011));
    check(flush_req == '0, "R8 repeat no flush", flush_req[63:32], 32'h0);
    next_tx(mk(1, 3, 16'h0011), "R8 repeat acked");
    rx_send(mk(0, 3, 16'h0001));
    check(partner_reset[52] == 1'b0 && partner_reset[48], "R6 clear", partner_reset[63:32], 32'h00010000);
    next_tx(mk(1, 3, 16'h0001), "R8 clear acked");

    // R11 foreign type
    rx_send({8'h71, 1'b0, 3'b000, 4'd4, 16'hffff});
    check(partner_reset[79:64] == 16'h0, "R11 mirror", partner_reset[95:64], 32'h0);
    expect_quiet(3, "R11 no ack");

    // R9 collision: ack and state wait together
    @(negedge clk); rx_valid = 1'b1; rx_dllp = mk(0, 7, 16'h8000);
    @(negedge clk); rx_valid = 1'b0; loc_reset[3] = 1'b1;
    next_tx(mk(1, 7, 16'h8000), "R9 ack first");
    next_tx(mk(0, 0, 16'h0008), "R9 state second");
    rx_send(mk(1, 0, 16'h0008));
    expect_quiet(3, "R9 settled");

    // R10 stall
    @(negedge clk); tx_ready = 1'b0; loc_reset[100] = 1'b1;
    next_tx(mk(0, 6, 16'h0010), "R10 offered");
    rx_send(mk(0, 9, 16'h0003));
    check(flush_req[144] && flush_req[145], "R10 flush during stall", flush_req[159:128], 32'h00030000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(tx_valid && tx_dllp == mk(0, 6, 16'h0010), "R10 hold", tx_dllp, mk(0, 6, 16'h0010));
    end
    tx_ready = 1'b1;
    next_tx(mk(1, 9, 16'h0003), "R10 ack after stall");
    rx_send(mk(1, 6, 16'h0010));
    expect_quiet(3, "R10 settled");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule